// File: doc/BRIEF.md
# UART with multiprocessor address filtering

This block is a full-duplex asynchronous serial transceiver. Characters written into an eight-entry transmit queue are serialized on `txd`. Characters arriving on `rxd` are deserialized into an eight-entry receive queue. The receive queue shows its oldest entry at its output together with that entry's status flags. All bit timing comes from an external tick pulse at sixteen times the bit rate. The baud generator and any handshake lines are outside the block.

A frame may carry a ninth bit and a parity bit, each chosen by configuration. With the ninth bit enabled, a set ninth bit marks the character as an address. The receiver compares every address with its own node address. It passes data characters only while the most recent address matched, so several nodes can share one pair of lines and each sees only its own traffic. The receiver flags parity errors, framing errors and line breaks with each stored entry. If a character arrives while the receive queue is full, the block drops it and sets a sticky overflow flag.

Top module: `uart_mp`

## Requirements
- R1: A transmitted frame is, in order: one low start bit, eight data bits with the least significant first, the ninth bit when `cfg_mp_en` is 1, the parity bit when `cfg_parity_en` is 1, and one high stop bit. Each bit lasts 16 ticks, and `txd` rests high while nothing is being sent.
- R2: The transmit queue holds 8 characters. `tx_full` is 1 while it holds 8, and a write while `tx_full` is 1 is discarded.
- R3: Received characters appear at the receive queue output (`rx_data`, with the ninth bit at position 8) in arrival order. A one-cycle `rx_rd` pulse while `rx_empty` is 0 removes the shown entry. With `cfg_mp_en` at 0, `rx_data[8]` reads 0.
- R4: The parity bit makes the number of ones over the eight data bits, the ninth bit (when enabled) and the parity bit even when `cfg_parity_odd` is 0, and odd when it is 1. A received character whose parity disagrees is stored with `rx_perr` set to 1.
- R5: A character whose stop bit is sampled low, while at least one other bit was high, is stored with `rx_ferr` set to 1. The receiver then waits for the line to return high before it looks for a new start bit.
- R6: When the start bit, every data, ninth and parity bit, and the stop bit are all sampled low, exactly one entry is stored, with `rx_brk` 1, `rx_data` 0 and both error flags 0. Nothing more is stored until the line goes high and a new frame begins.
- R7: A low pulse on `rxd` that is no longer low at the middle of the start bit is ignored, and no entry is stored.
- R8: With `cfg_mp_en` at 1, an address character (ninth bit 1) is stored only if its low eight bits equal `cfg_node_addr`. The match result is kept, and a data character is stored only while the last address received matched. After reset, no address has matched.
- R9: The receive queue holds 8 entries. A character completed while it is full is dropped and `rx_ovf` is set to 1, and `rx_ovf` stays 1 until reset.
- R10: After reset: `txd` is 1, `tx_empty` is 1, `tx_full` is 0, `rx_empty` is 1 and `rx_ovf` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfg_parity_en | input | 1 | Append and check a parity bit |
| cfg_parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_mp_en | input | 1 | Ninth-bit address marking and filtering |
| cfg_node_addr | input | 8 | Address this node answers to |
| tx_wr | input | 1 | Write `tx_data` into the transmit queue |
| tx_data | input | 9 | Character; bit 8 is the address mark |
| tx_full | output | 1 | Transmit queue holds 8 characters |
| tx_empty | output | 1 | Transmit queue is empty |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_rd | input | 1 | Remove the shown receive entry |
| rx_empty | output | 1 | Receive queue is empty |
| rx_data | output | 9 | Oldest received character |
| rx_perr | output | 1 | Parity error on the shown entry |
| rx_ferr | output | 1 | Framing error on the shown entry |
| rx_brk | output | 1 | Shown entry is a break |
| rx_ovf | output | 1 | Sticky receive overflow |

## Verification
The bench builds the block with its default parameters: queue depth 8 and sixteen ticks per bit, with a tick on every second clock. This makes the full queue corner, and the ninth character arriving at a full receive queue, reachable in a few thousand cycles. Most traffic runs with `txd` looped back to `rxd` under random parity settings and random address sequences. Parity errors, framing errors, breaks and start-bit glitches are driven bit by bit onto `rxd` directly.

// File: rtl/uart_mp.sv
module uart_mp #(
  parameter int DEPTH = 8,
  parameter int OVS   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cfg_parity_en,
  input  logic       cfg_parity_odd,
  input  logic       cfg_mp_en,
  input  logic [7:0] cfg_node_addr,
  input  logic       tx_wr,
  input  logic [8:0] tx_data,
  output logic       tx_full,
  output logic       tx_empty,
  output logic       txd,
  input  logic       rxd,
  input  logic       rx_rd,
  output logic       rx_empty,
  output logic [8:0] rx_data,
  output logic       rx_perr,
  output logic       rx_ferr,
  output logic       rx_brk,
  output logic       rx_ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(OVS);
  localparam logic [AW:0]   FULLN = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LASTP = AW'(DEPTH-1);
  localparam logic [CW-1:0] CLAST = CW'(OVS-1);
  localparam logic [CW-1:0] CMID  = CW'(OVS/2-1);

  // transmit queue
  logic [8:0]    txq [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [AW:0]   tx_n;
  logic          tx_push, tx_pop;

  assign tx_full  = (tx_n == FULLN);
  assign tx_empty = (tx_n == '0);
  assign tx_push  = tx_wr && !tx_full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0;
      tx_rp <= '0;
      tx_n  <= '0;
    end else begin
      if (tx_push) tx_wp <= (tx_wp == LASTP) ? '0 : tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= (tx_rp == LASTP) ? '0 : tx_rp + 1'b1;
      tx_n <= tx_n + {{AW{1'b0}}, tx_push} - {{AW{1'b0}}, tx_pop};
    end

  always_ff @(posedge clk)
    if (tx_push) txq[tx_wp] <= tx_data;

  // transmit shifter
  logic          tx_busy;
  logic [11:0]   tx_sh, tx_frame;
  logic [3:0]    tx_left, tx_nbits;
  logic [CW-1:0] tx_cnt;
  logic [8:0]    tx_head;
  logic          tx_pb;

  assign tx_head  = txq[tx_rp];
  assign tx_pb    = ^tx_head[7:0] ^ (cfg_mp_en & tx_head[8]) ^ cfg_parity_odd;
  assign tx_nbits = 4'd10 + {3'b0, cfg_mp_en} + {3'b0, cfg_parity_en};
  assign tx_pop   = !tx_busy && !tx_empty && tick;
  assign txd      = tx_busy ? tx_sh[0] : 1'b1;

  always_comb
    case ({cfg_mp_en, cfg_parity_en})
      2'b00:   tx_frame = {3'b111, tx_head[7:0], 1'b0};
      2'b10:   tx_frame = {2'b11, tx_head[8], tx_head[7:0], 1'b0};
      2'b01:   tx_frame = {2'b11, tx_pb, tx_head[7:0], 1'b0};
      default: tx_frame = {1'b1, tx_pb, tx_head[8], tx_head[7:0], 1'b0};
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_left <= '0;
      tx_cnt  <= '0;
    end else if (tx_pop) begin
      tx_busy <= 1'b1;
      tx_sh   <= tx_frame;
      tx_left <= tx_nbits;
      tx_cnt  <= '0;
    end else if (tx_busy && tick) begin
      if (tx_cnt == CLAST) begin
        tx_cnt  <= '0;
        tx_sh   <= {1'b1, tx_sh[11:1]};
        tx_left <= tx_left - 1'b1;
        if (tx_left == 4'd1) tx_busy <= 1'b0;
      end else begin
        tx_cnt <= tx_cnt + 1'b1;
      end
    end

  // receive sampler
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_STOP, R_WAIT} rx_st_t;
  rx_st_t        rx_st;
  logic [1:0]    rx_sync;
  logic          rxs;
  logic [CW-1:0] rx_cnt;
  logic [3:0]    rx_idx, rx_nb;
  logic [9:0]    rx_sh;
  logic          mp_match;

  assign rxs   = rx_sync[1];
  assign rx_nb = 4'd8 + {3'b0, cfg_mp_en} + {3'b0, cfg_parity_en};

  logic rx_b8, rx_pb, rx_zero, rx_done, rx_brk_now, rx_ferr_now, rx_perr_now;
  logic rx_is_addr, rx_hit, rx_accept, rx_push;
  logic [11:0] rx_entry;

  assign rx_b8       = cfg_mp_en & rx_sh[8];
  assign rx_pb       = cfg_mp_en ? rx_sh[9] : rx_sh[8];
  assign rx_zero     = ~|rx_sh;
  assign rx_done     = (rx_st == R_STOP) && tick && (rx_cnt == CLAST);
  assign rx_brk_now  = !rxs && rx_zero;
  assign rx_ferr_now = !rxs && !rx_zero;
  assign rx_perr_now = cfg_parity_en & (^rx_sh[7:0] ^ rx_b8 ^ cfg_parity_odd ^ rx_pb);
  assign rx_is_addr  = rx_b8 && !rx_brk_now;
  assign rx_hit      = (rx_sh[7:0] == cfg_node_addr);
  assign rx_accept   = rx_brk_now || !cfg_mp_en || (rx_is_addr ? rx_hit : mp_match);
  assign rx_push     = rx_done && rx_accept;
  assign rx_entry    = rx_brk_now ? 12'h800
                                  : {1'b0, rx_ferr_now, rx_perr_now, rx_b8, rx_sh[7:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sync  <= 2'b11;
      rx_st    <= R_IDLE;
      rx_cnt   <= '0;
      rx_idx   <= '0;
      rx_sh    <= '0;
      mp_match <= 1'b0;
    end else begin
      rx_sync <= {rx_sync[0], rxd};
      if (tick)
        case (rx_st)
          R_IDLE:
            if (!rxs) begin
              rx_st  <= R_START;
              rx_cnt <= '0;
            end
          R_START:
            if (rx_cnt == CMID) begin
              rx_cnt <= '0;
              rx_idx <= '0;
              rx_sh  <= '0;
              rx_st  <= rxs ? R_IDLE : R_DATA;
            end else rx_cnt <= rx_cnt + 1'b1;
          R_DATA:
            if (rx_cnt == CLAST) begin
              rx_cnt        <= '0;
              rx_sh[rx_idx] <= rxs;
              rx_idx        <= rx_idx + 1'b1;
              if (rx_idx == rx_nb - 4'd1) rx_st <= R_STOP;
            end else rx_cnt <= rx_cnt + 1'b1;
          R_STOP:
            if (rx_cnt == CLAST) begin
              rx_cnt <= '0;
              rx_st  <= rxs ? R_IDLE : R_WAIT;
              if (rx_is_addr) mp_match <= rx_hit;
            end else rx_cnt <= rx_cnt + 1'b1;
          default:
            if (rxs) rx_st <= R_IDLE;
        endcase
    end

  // receive queue
  logic [11:0]   rxq [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [AW:0]   rx_n;
  logic          rx_full, rx_wr, rx_pop;
  logic [11:0]   rx_head;

  assign rx_full  = (rx_n == FULLN);
  assign rx_empty = (rx_n == '0);
  assign rx_wr    = rx_push && !rx_full;
  assign rx_pop   = rx_rd && !rx_empty;
  assign rx_head  = rxq[rx_rp];
  assign rx_data  = rx_head[8:0];
  assign rx_perr  = rx_head[9];
  assign rx_ferr  = rx_head[10];
  assign rx_brk   = rx_head[11];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_n   <= '0;
      rx_ovf <= 1'b0;
    end else begin
      if (rx_wr)  rx_wp <= (rx_wp == LASTP) ? '0 : rx_wp + 1'b1;
      if (rx_pop) rx_rp <= (rx_rp == LASTP) ? '0 : rx_rp + 1'b1;
      rx_n <= rx_n + {{AW{1'b0}}, rx_wr} - {{AW{1'b0}}, rx_pop};
      if (rx_push && rx_full) rx_ovf <= 1'b1;
    end

  always_ff @(posedge clk)
    if (rx_wr) rxq[rx_wp] <= rx_entry;

endmodule

// File: rtl/uart_mp_chk.sv
module uart_mp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       tx_busy,
  input logic       tx_wr,
  input logic       tx_full,
  input logic       tx_empty,
  input logic       rx_empty,
  input logic [8:0] rx_data,
  input logic       rx_perr,
  input logic       rx_ferr,
  input logic       rx_brk,
  input logic       rx_ovf,
  input logic       rx_push,
  input logic       rx_full
);
  assert_txd_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  assert_wr_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && !tx_full) |=> !tx_empty);

  assert_brk_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_empty && rx_brk) |-> (rx_data == 9'd0 && !rx_perr && !rx_ferr));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full) |=> rx_ovf);

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |=> rx_ovf);
endmodule

bind uart_mp uart_mp_chk chk_i (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tx_busy(tx_busy), .tx_wr(tx_wr),
  .tx_full(tx_full), .tx_empty(tx_empty), .rx_empty(rx_empty),
  .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
  .rx_ovf(rx_ovf), .rx_push(rx_push), .rx_full(rx_full)
);

// File: tb/uart_mp_tb_top.sv
module uart_mp_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BITCLK     = 32;

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic       par_en = 1'b0, par_odd = 1'b0, mp_en = 1'b0;
  logic [7:0] node = 8'h00;
  logic       tx_wr = 1'b0, rx_rd = 1'b0, loop = 1'b1, rxd_drv = 1'b1;
  logic [8:0] tx_data = '0;
  logic       tx_full, tx_empty, txd, rx_empty, rx_perr, rx_ferr, rx_brk, rx_ovf;
  logic [8:0] rx_data;
  logic       rxd;
  int checks = 0, errors = 0;

  assign rxd = loop ? txd : rxd_drv;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  uart_mp dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cfg_parity_en(par_en), .cfg_parity_odd(par_odd), .cfg_mp_en(mp_en),
    .cfg_node_addr(node), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_full(tx_full), .tx_empty(tx_empty), .txd(txd), .rxd(rxd),
    .rx_rd(rx_rd), .rx_empty(rx_empty), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rx_ovf(rx_ovf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic pbit(input logic [8:0] d, input logic mp, input logic odd);
    return (^d[7:0]) ^ (mp & d[8]) ^ odd;
  endfunction

  function automatic logic [11:0] frame(input logic [8:0] d, input logic mp,
                                        input logic par, input logic odd, output int n);
    logic [11:0] f;
    int k;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[i+1] = d[i];
    k = 9;
    if (mp)  begin f[k] = d[8]; k++; end
    if (par) begin f[k] = pbit(d, mp, odd); k++; end
    n = k + 1;
    return f;
  endfunction

  task automatic send(input logic [8:0] d);
    @(negedge clk);
    while (tx_full) @(negedge clk);
    tx_wr = 1'b1; tx_data = d;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic drain_wait();
    while (!tx_empty) @(negedge clk);
    repeat (500) @(negedge clk);
  endtask

  task automatic send_raw(input logic [11:0] f, input int n);
    for (int i = 0; i < n; i++) begin
      rxd_drv = f[i];
      repeat (BITCLK) @(negedge clk);
    end
    rxd_drv = 1'b1;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic expect_rx(input logic [8:0] d, input logic pe, input logic fe,
                           input logic bk, input string req);
    @(negedge clk);
    chk(!rx_empty && rx_data == d && rx_perr == pe && rx_ferr == fe && rx_brk == bk,
        req, {rx_empty, rx_brk, rx_ferr, rx_perr, rx_data},
        {1'b0, bk, fe, pe, d});
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  task automatic expect_empty(input string req);
    @(negedge clk);
    chk(rx_empty, req, rx_empty, 1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd && tx_empty && !tx_full && rx_empty && !rx_ovf, "R10",
        {txd, tx_empty, tx_full, rx_empty, rx_ovf}, 5'b11010);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [8:0]  q [8];
    logic [11:0] f;
    int n, cnt;
    bit match;
    void'($urandom(32'd1234));
    do_reset();

    // R1: frame shape on txd, odd parity
    par_en = 1; par_odd = 1; mp_en = 0;
    f = frame(9'h0A5, 0, 1, 1, n);
    send(9'h0A5);
    while (txd) @(negedge clk);
    repeat (16) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      chk(txd == f[i], "R1", txd, f[i]);
      repeat (BITCLK) @(negedge clk);
    end
    drain_wait();
    expect_rx(9'h0A5, 0, 0, 0, "R3");
    expect_empty("R3");

    // R3/R4: random loopback with random parity settings
    for (int r = 0; r < 12; r++) begin
      par_en = 1'($urandom); par_odd = 1'($urandom); mp_en = 0;
      cnt = 1 + $urandom % 8;
      for (int i = 0; i < cnt; i++) begin
        q[i] = {1'b0, 8'($urandom)};
        send({1'b1, q[i][7:0]});
      end
      drain_wait();
      for (int i = 0; i < cnt; i++) expect_rx(q[i], 0, 0, 0, "R3_R4");
      expect_empty("R3");
    end

    // R8: address filtering
    mp_en = 1; node = 8'h5A; match = 0;
    for (int b = 0; b < 4; b++) begin
      par_en = 1'($urandom); par_odd = 1'($urandom);
      cnt = 0;
      for (int i = 0; i < 8; i++) begin
        logic [8:0] d;
        case ($urandom % 4)
          0: d = {1'b1, node};
          1: d = {1'b1, node ^ 8'(1 + $urandom % 255)};
          default: d = {1'b0, 8'($urandom)};
        endcase
        if (b == 0 && i == 0) d = {1'b0, 8'h33};
        if (d[8]) match = (d[7:0] == node);
        if (match) begin q[cnt] = d; cnt++; end
        send(d);
      end
      drain_wait();
      for (int i = 0; i < cnt; i++) expect_rx(q[i], 0, 0, 0, "R8");
      expect_empty("R8");
    end

    // R4: bad parity driven directly
    loop = 0; mp_en = 0; par_en = 1; par_odd = 0;
    f = frame(9'h03C, 0, 1, 0, n);
    f[9] = ~f[9];
    send_raw(f, n);
    repeat (100) @(negedge clk);
    expect_rx(9'h03C, 1, 0, 0, "R4");

    // R5: stop bit low
    par_en = 0;
    f = frame(9'h081, 0, 0, 0, n);
    f[9] = 1'b0;
    send_raw(f, n);
    repeat (600) @(negedge clk);
    expect_rx(9'h081, 0, 1, 0, "R5");
    expect_empty("R5");

    // R6: break longer than a frame
    par_en = 1;
    rxd_drv = 0;
    repeat (BITCLK * 14) @(negedge clk);
    rxd_drv = 1;
    repeat (400) @(negedge clk);
    expect_rx(9'h000, 0, 0, 1, "R6");
    expect_empty("R6");

    // R7: short glitch
    rxd_drv = 0;
    repeat (6) @(negedge clk);
    rxd_drv = 1;
    repeat (1000) @(negedge clk);
    expect_empty("R7");
    f = frame(9'h0C3, 0, 1, 0, n);
    send_raw(f, n);
    repeat (100) @(negedge clk);
    expect_rx(9'h0C3, 0, 0, 0, "R7");

    // R2/R9: full transmit queue, then receive overflow
    loop = 1; par_en = 0;
    for (int i = 0; i < 9; i++) begin
      tx_wr = 1; tx_data = 9'(8'h10 + i);
      @(negedge clk);
    end
    tx_wr = 0;
    chk(tx_full, "R2", tx_full, 1);
    tx_wr = 1; tx_data = 9'h0EE;
    @(negedge clk);
    tx_wr = 0;
    drain_wait();
    chk(rx_ovf, "R9", rx_ovf, 1);
    for (int i = 0; i < 8; i++) expect_rx(9'(8'h10 + i), 0, 0, 0, "R9");
    expect_empty("R2_R9");
    chk(rx_ovf, "R9 sticky", rx_ovf, 1);

    do_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule